// File: doc/BRIEF.md
# Instruction Queue with Branch Split-Off

This block sits between an instruction fetch buffer and the execution units. It keeps up to four fetched instructions in program order. Each fetched word comes with a predecode flag that marks it as a branch. Every accepted word is written into the queue, branches included. Non-branch words leave toward the execution units through an issue port with a valid/ready handshake. Branch words leave through a separate branch port that is always accepted. Because of this split, a lone branch does not use up an issue slot.

Each cycle the block looks at the two oldest entries. At most one non-branch word and at most one branch word leave per cycle. When the oldest entry is a branch, it is removed whether or not the execution units are ready, and a non-branch word right behind it may issue in the same cycle. When the oldest entry is a non-branch word and it issues, a branch directly behind it is removed together with it. Only a run of adjacent branches at the front of the queue leaves the issue port idle.

The queue also covers gaps in the fetch stream, such as cache misses, by issuing from entries it already holds. A flush input empties the queue in one cycle, for use after a mispredicted branch.

The fill level is tracked by a small state machine with three states:
- `ST_EMPTY`: no entries.
- `ST_PARTIAL`: one to three entries.
- `ST_FULL`: four entries.

Its transitions are:
- fill: `ST_EMPTY` to `ST_PARTIAL`.
- drain: `ST_PARTIAL` to `ST_EMPTY`.
- top-off: `ST_PARTIAL` to `ST_FULL`.
- release: `ST_FULL` to `ST_PARTIAL`.
- flush: any state to `ST_EMPTY`.
- hold: the state stays as it is.

Top module: `instr_queue_bsplit`

## Requirements
- R1: While reset is active and in the first cycle after it, the queue is empty: `fetch_ready`=1, `issue_valid`=0, `branch_valid`=0.
- R2: A word is accepted when `fetch_valid` and `fetch_ready` are both 1 at a clock edge. Accepted words leave in program order. A word accepted at one edge can first leave in the cycle after that edge.
- R3: When the oldest entry is a non-branch word, `issue_valid`=1 and `issue_word` carries it. The word is removed when `issue_ready`=1.
- R4: A word fetched with `fetch_is_branch`=1 never appears on the issue port. It leaves only through `branch_valid`/`branch_word`, and at most one branch leaves per cycle.
- R5: Suppose the oldest entry is a non-branch word that issues with `issue_ready`=1, and the second entry is a branch. Then both leave in the same cycle.
- R6: When the oldest entry is a branch, `branch_valid`=1 with that word, whatever the value of `issue_ready`. If the second entry is a non-branch word, it is offered on the issue port in the same cycle.
- R7: When the two oldest entries are both branches, only the oldest is removed, and `issue_valid`=0 in that cycle.
- R8: When the oldest entry is a non-branch word and `issue_ready`=0, nothing leaves: `branch_valid`=0 even if the second entry is a branch.
- R9: `fetch_ready`=0 exactly when either of these holds:
  - all four entries are held and no entry leaves in that cycle;
  - `flush`=1.
- R10: While `fetch_valid`=0, the entries already held keep issuing, one per cycle while `issue_ready`=1.
- R11: `flush`=1 forces `issue_valid`=0, `branch_valid`=0 and `fetch_ready`=0 in that cycle. After the edge the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the queue (after a misprediction) |
| fetch_valid | input | 1 | Fetch buffer offers a word |
| fetch_is_branch | input | 1 | Predecode flag: offered word is a branch |
| fetch_word | input | W (32) | Offered instruction word |
| fetch_ready | output | 1 | Queue can accept the offered word this cycle |
| issue_valid | output | 1 | Non-branch word available to the execution units |
| issue_word | output | W (32) | Word on the issue port |
| issue_ready | input | 1 | Execution units take the issue word |
| branch_valid | output | 1 | Branch word handed to the branch unit this cycle |
| branch_word | output | W (32) | Word on the branch port |

## Verification
The queue is first preloaded while the issue port is stalled, and then released. This is done with several orders of entries:
- Alternating non-branch and branch words show whether a branch travels alongside the issuing word instead of taking a cycle of its own.
- A branch that ends up oldest, with a non-branch word behind it, tells apart unconditional branch removal and issue-gated removal.
- Three branches in a row show the single-branch-per-cycle limit and the resulting issue bubble.

A full queue with a fifth word waiting checks back-pressure and its release by a same-cycle issue. Draining with no fetch then checks that issue continues through a fetch gap. A flush applied while a fetch is offered checks that nothing is accepted or emitted in that cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;

    // Per-cycle departure decision taken from the two oldest entries
    typedef struct packed {
        logic       issue_vld;  // a non-branch word is offered
        logic       issue_sel;  // 0: oldest entry, 1: second entry
        logic       br_vld;     // a branch word leaves
        logic       br_sel;     // 0: oldest entry, 1: second entry
        logic [1:0] pops;       // entries leaving this cycle
    } leave_t;

endpackage

// File: rtl/iq_occ_fsm.sv
module iq_occ_fsm
    import iq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          fetch_valid,
    input  logic [1:0]    pops,
    output logic          push,
    output logic          fetch_ready,
    output logic [CW-1:0] count,
    output occ_state_e    state
);

    occ_state_e    state_n;
    logic [CW-1:0] count_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            count <= '0;
        end else begin
            state <= state_n;
            count <= count_n;
        end
    end

    // Next-state logic
    always_comb begin
        int sum;
        sum     = int'(count) + int'(push) - int'(pops);
        count_n = CW'(sum);
        state_n = state;
        if (flush) begin
            count_n = '0;
            state_n = ST_EMPTY;                 // flush
        end else begin
            unique case (state)
                ST_EMPTY: begin
                    if (push) state_n = (sum == DEPTH) ? ST_FULL : ST_PARTIAL; // fill
                end
                ST_PARTIAL: begin
                    if (sum == 0)          state_n = ST_EMPTY;   // drain
                    else if (sum == DEPTH) state_n = ST_FULL;    // top-off
                end
                ST_FULL: begin
                    if (sum == 0)          state_n = ST_EMPTY;
                    else if (sum < DEPTH)  state_n = ST_PARTIAL; // release
                end
                default: state_n = ST_EMPTY;
            endcase
        end
    end

    // Outputs
    always_comb begin
        fetch_ready = !flush && ((state != ST_FULL) || (pops != 2'd0));
        push        = fetch_valid && fetch_ready;
    end

endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
(
    input  logic   flush,
    input  logic   head_vld,
    input  logic   head_br,
    input  logic   sec_vld,
    input  logic   sec_br,
    input  logic   issue_ready,
    output leave_t leave
);

    always_comb begin
        leave = '0;
        if (!flush && head_vld) begin
            if (head_br) begin
                // oldest is a branch: it goes regardless of issue_ready
                leave.br_vld = 1'b1;
                leave.br_sel = 1'b0;
                if (sec_vld && !sec_br) begin
                    leave.issue_vld = 1'b1;
                    leave.issue_sel = 1'b1;
                    leave.pops      = issue_ready ? 2'd2 : 2'd1;
                end else begin
                    leave.pops      = 2'd1;
                end
            end else begin
                leave.issue_vld = 1'b1;
                leave.issue_sel = 1'b0;
                if (issue_ready) begin
                    if (sec_vld && sec_br) begin
                        leave.br_vld = 1'b1;
                        leave.br_sel = 1'b1;
                        leave.pops   = 2'd2;
                    end else begin
                        leave.pops   = 2'd1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/iq_store.sv
module iq_store #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          push_br,
    input  logic [W-1:0]  push_word,
    input  logic [1:0]    pops,
    input  logic [CW-1:0] count,
    output logic          br_q   [DEPTH],
    output logic [W-1:0]  word_q [DEPTH]
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam int NX1 = (g + 1 < DEPTH) ? g + 1 : g;
        localparam int NX2 = (g + 2 < DEPTH) ? g + 2 : g;

        logic         br_n;
        logic [W-1:0] word_n;

        always_comb begin
            br_n   = br_q[g];
            word_n = word_q[g];
            if (g + int'(pops) < int'(count)) begin
                case (pops)
                    2'd1: begin
                        br_n   = br_q[NX1];
                        word_n = word_q[NX1];
                    end
                    2'd2: begin
                        br_n   = br_q[NX2];
                        word_n = word_q[NX2];
                    end
                    default: ;
                endcase
            end else if (push && (g == int'(count) - int'(pops))) begin
                br_n   = push_br;
                word_n = push_word;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                br_q[g]   <= 1'b0;
                word_q[g] <= '0;
            end else if (flush) begin
                br_q[g]   <= 1'b0;
            end else begin
                br_q[g]   <= br_n;
                word_q[g] <= word_n;
            end
        end
    end

endmodule

// File: rtl/instr_queue_bsplit.sv
module instr_queue_bsplit
    import iq_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         fetch_valid,
    input  logic         fetch_is_branch,
    input  logic [W-1:0] fetch_word,
    output logic         fetch_ready,
    output logic         issue_valid,
    output logic [W-1:0] issue_word,
    input  logic         issue_ready,
    output logic         branch_valid,
    output logic [W-1:0] branch_word
);

    leave_t        leave;
    occ_state_e    occ_state;
    logic [CW-1:0] occ_cnt;
    logic          push;
    logic          head_vld, head_br, sec_vld, sec_br;
    logic          occ_full, occ_empty;
    logic          br_q   [DEPTH];
    logic [W-1:0]  word_q [DEPTH];

    assign head_vld  = (occ_cnt != '0);
    assign sec_vld   = (occ_cnt > CW'(1));
    assign head_br   = br_q[0];
    assign sec_br    = br_q[1];
    assign occ_full  = (occ_state == ST_FULL);
    assign occ_empty = (occ_state == ST_EMPTY);

    iq_occ_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .fetch_valid (fetch_valid),
        .pops        (leave.pops),
        .push        (push),
        .fetch_ready (fetch_ready),
        .count       (occ_cnt),
        .state       (occ_state)
    );

    iq_select u_sel (
        .flush       (flush),
        .head_vld    (head_vld),
        .head_br     (head_br),
        .sec_vld     (sec_vld),
        .sec_br      (sec_br),
        .issue_ready (issue_ready),
        .leave       (leave)
    );

    iq_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_br   (fetch_is_branch),
        .push_word (fetch_word),
        .pops      (leave.pops),
        .count     (occ_cnt),
        .br_q      (br_q),
        .word_q    (word_q)
    );

    always_comb begin
        issue_valid  = leave.issue_vld;
        issue_word   = leave.issue_sel ? word_q[1] : word_q[0];
        branch_valid = leave.br_vld;
        branch_word  = leave.br_sel ? word_q[1] : word_q[0];
    end

endmodule

// File: rtl/iq_checker.sv
module iq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       issue_ready,
    input logic       issue_valid,
    input logic       branch_valid,
    input logic       fetch_ready,
    input logic       occ_full,
    input logic       occ_empty,
    input logic [1:0] pops,
    input logic       head_vld,
    input logic       head_br,
    input logic       sec_vld,
    input logic       sec_br
);

    a_r5_branch_rides_along: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && head_vld && !head_br && issue_ready && sec_vld && sec_br)
        |-> (issue_valid && branch_valid && pops == 2'd2));

    a_r6_head_branch_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && head_vld && head_br) |-> branch_valid);

    a_r7_pair_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && head_vld && head_br && sec_vld && sec_br)
        |-> (branch_valid && !issue_valid && pops == 2'd1));

    a_r8_stalled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && head_vld && !head_br && !issue_ready) |-> (!branch_valid && pops == 2'd0));

    a_r9_stall_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_ready && !flush) |-> (occ_full && pops == 2'd0));

    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ_empty && !issue_valid && !branch_valid));

endmodule

bind instr_queue_bsplit iq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .issue_ready  (issue_ready),
    .issue_valid  (issue_valid),
    .branch_valid (branch_valid),
    .fetch_ready  (fetch_ready),
    .occ_full     (occ_full),
    .occ_empty    (occ_empty),
    .pops         (leave.pops),
    .head_vld     (head_vld),
    .head_br      (head_br),
    .sec_vld      (sec_vld),
    .sec_br       (sec_br)
);

// File: tb/instr_queue_bsplit_tb.sv
module instr_queue_bsplit_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         fetch_valid = 1'b0;
    logic         fetch_is_branch = 1'b0;
    logic [W-1:0] fetch_word = '0;
    logic         issue_ready = 1'b0;
    logic         fetch_ready, issue_valid, branch_valid;
    logic [W-1:0] issue_word, branch_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    instr_queue_bsplit #(.W(W), .DEPTH(4)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .flush           (flush),
        .fetch_valid     (fetch_valid),
        .fetch_is_branch (fetch_is_branch),
        .fetch_word      (fetch_word),
        .fetch_ready     (fetch_ready),
        .issue_valid     (issue_valid),
        .issue_word      (issue_word),
        .issue_ready     (issue_ready),
        .branch_valid    (branch_valid),
        .branch_word     (branch_word)
    );

    function automatic logic [W-1:0] nb(input int k);
        return 32'h1000_0000 + W'(k);
    endfunction

    function automatic logic [W-1:0] br(input int k);
        return 32'hB000_0000 + W'(k);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // move to 5 ns after the next rising edge; inputs change there
    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic expect_out(input string req, input logic iv, input logic [W-1:0] iw,
                              input logic bv, input logic [W-1:0] bw);
        #1;
        chk(req, "issue_valid", 64'(issue_valid), 64'(iv));
        if (iv) chk(req, "issue_word", 64'(issue_word), 64'(iw));
        chk(req, "branch_valid", 64'(branch_valid), 64'(bv));
        if (bv) chk(req, "branch_word", 64'(branch_word), 64'(bw));
    endtask

    task automatic push_one(input logic [W-1:0] w, input logic is_br);
        fetch_valid     = 1'b1;
        fetch_word      = w;
        fetch_is_branch = is_br;
        cyc();
        fetch_valid     = 1'b0;
        fetch_is_branch = 1'b0;
    endtask

    task automatic clear_queue();
        issue_ready = 1'b0;
        flush = 1'b1;
        cyc();
        flush = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #1;
        chk("R1", "issue_valid in reset", 64'(issue_valid), 64'd0);
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;
        #1;
        chk("R1", "fetch_ready", 64'(fetch_ready), 64'd1);
        chk("R1", "issue_valid", 64'(issue_valid), 64'd0);
        chk("R1", "branch_valid", 64'(branch_valid), 64'd0);
        cyc();
    endtask

    // N B N B preloaded: each branch leaves with the word ahead of it
    task automatic t_alternating();
        clear_queue();
        push_one(nb(0), 1'b0);
        push_one(br(0), 1'b1);
        push_one(nb(1), 1'b0);
        push_one(br(1), 1'b1);
        issue_ready = 1'b1;
        expect_out("R5", 1'b1, nb(0), 1'b1, br(0));
        cyc();
        expect_out("R5", 1'b1, nb(1), 1'b1, br(1));
        cyc();
        expect_out("R3", 1'b0, '0, 1'b0, '0);
        cyc();
    endtask

    // branch reaches the head with a non-branch behind it
    task automatic t_head_branch();
        clear_queue();
        push_one(nb(0), 1'b0);
        push_one(br(0), 1'b1);
        push_one(br(1), 1'b1);
        push_one(nb(1), 1'b0);
        issue_ready = 1'b1;
        expect_out("R5", 1'b1, nb(0), 1'b1, br(0));
        cyc();
        issue_ready = 1'b0;
        expect_out("R6", 1'b1, nb(1), 1'b1, br(1));
        cyc();
        issue_ready = 1'b1;
        expect_out("R3", 1'b1, nb(1), 1'b0, '0);
        cyc();
        expect_out("R3", 1'b0, '0, 1'b0, '0);
        cyc();
    endtask

    // three branches in a row: one per cycle, issue bubble
    task automatic t_branch_pair();
        clear_queue();
        push_one(nb(0), 1'b0);
        push_one(br(0), 1'b1);
        push_one(br(1), 1'b1);
        push_one(br(2), 1'b1);
        issue_ready = 1'b1;
        expect_out("R5", 1'b1, nb(0), 1'b1, br(0));
        cyc();
        expect_out("R7", 1'b0, '0, 1'b1, br(1));
        cyc();
        expect_out("R4", 1'b0, '0, 1'b1, br(2));
        cyc();
        expect_out("R4", 1'b0, '0, 1'b0, '0);
        cyc();
    endtask

    // stalled non-branch head keeps the branch behind it
    task automatic t_stall_hold();
        clear_queue();
        push_one(nb(0), 1'b0);
        push_one(br(0), 1'b1);
        expect_out("R8", 1'b1, nb(0), 1'b0, '0);
        cyc();
        expect_out("R8", 1'b1, nb(0), 1'b0, '0);
        issue_ready = 1'b1;
        expect_out("R5", 1'b1, nb(0), 1'b1, br(0));
        cyc();
        expect_out("R8", 1'b0, '0, 1'b0, '0);
        cyc();
    endtask

    // full queue back-pressure, then drain through a fetch gap
    task automatic t_full_and_gap();
        clear_queue();
        for (int k = 0; k < 4; k++) push_one(nb(k), 1'b0);
        fetch_valid = 1'b1;
        fetch_word  = nb(4);
        #1;
        chk("R9", "fetch_ready when full", 64'(fetch_ready), 64'd0);
        cyc();
        #1;
        chk("R9", "fetch_ready still full", 64'(fetch_ready), 64'd0);
        issue_ready = 1'b1;
        #1;
        chk("R9", "fetch_ready on same-cycle issue", 64'(fetch_ready), 64'd1);
        expect_out("R2", 1'b1, nb(0), 1'b0, '0);
        cyc();
        fetch_valid = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            expect_out("R10", 1'b1, nb(k), 1'b0, '0);
            cyc();
        end
        expect_out("R10", 1'b0, '0, 1'b0, '0);
        cyc();
    endtask

    task automatic t_flush();
        clear_queue();
        push_one(nb(0), 1'b0);
        push_one(nb(1), 1'b0);
        push_one(br(0), 1'b1);
        flush       = 1'b1;
        fetch_valid = 1'b1;
        fetch_word  = nb(9);
        issue_ready = 1'b1;
        #1;
        chk("R11", "fetch_ready during flush", 64'(fetch_ready), 64'd0);
        chk("R11", "issue_valid during flush", 64'(issue_valid), 64'd0);
        chk("R11", "branch_valid during flush", 64'(branch_valid), 64'd0);
        cyc();
        flush       = 1'b0;
        fetch_valid = 1'b0;
        #1;
        chk("R11", "issue_valid after flush", 64'(issue_valid), 64'd0);
        chk("R11", "fetch_ready after flush", 64'(fetch_ready), 64'd1);
        push_one(nb(5), 1'b0);
        expect_out("R2", 1'b1, nb(5), 1'b0, '0);
        cyc();
        expect_out("R11", 1'b0, '0, 1'b0, '0);
        cyc();
    endtask

    initial begin
        t_reset();
        t_alternating();
        t_head_branch();
        t_branch_pair();
        t_stall_hold();
        t_full_and_gap();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule